// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter with Power Sequencing

This block sits between two pipelined converter cores and the chip's two parallel result buses. Each cycle it takes one offset-binary code per channel and carries both through a fixed-depth alignment pipeline. The codes leave on the same clock edge, five edges after they were captured. At the output register it can flip the most significant bit, so the buses carry either offset binary or two's complement. An active-low enable puts both buses into high impedance without disturbing the pipeline.

Two power-save requests are handled. A light sleep stops the converters. A full shutdown takes priority over sleep whenever both are requested. In either state the output registers freeze, so an enabled bus keeps presenting the last result. On release, a waking period with a parameterised cycle count must elapse before conversion resumes. The count for leaving shutdown is longer than the count for leaving sleep. The valid flags stay low until the pipeline has refilled with fresh samples. A two-bit mode output reports the current power state.

Top module: `adc_pair_outfmt`

## Requirements
- R1: While reset is held, mode reads 0 (active), both valid flags are low and the enabled buses read zero.
- R2: A code pair captured on rising edge k appears on both buses on edge k+5, with valid_a and valid_b high together; every active cycle yields exactly one such output.
- R3: With fmt_twos low the bus equals the captured code; with fmt_twos high bit 9 is inverted (0x200 becomes 0x000, 0x3FF becomes 0x1FF).
- R4: With oe_n high both buses are high impedance. Samples keep flowing through the pipeline and appear on time once oe_n is low again.
- R5: pwr_dn high puts mode at 2 (shutdown) from the next edge. The valid flags drop, and the buses hold their last value while oe_n is low. With oe_n high they float.
- R6: sleep high with pwr_dn low puts mode at 1 (sleep) from the next edge, with the valid flags low and the enabled buses held.
- R7: After sleep is released, mode reads 3 (waking) for exactly WAKE_SLEEP cycles (default 17) and then 0. The valid flags return only through the R2 pipeline refill.
- R8: After shutdown is released, mode reads 3 for exactly WAKE_OFF cycles (default 60) and then 0.
- R9: When pwr_dn and sleep are both high, mode is 2. Shutdown persists while either request stays high. Leaving it uses the WAKE_OFF delay.
- R10: A sleep request during waking returns mode to 1, and a pwr_dn request during waking returns mode to 2. The count restarts on the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_twos | input | 1 | 1 selects two's complement output coding, 0 offset binary |
| oe_n | input | 1 | Active-low bus enable |
| sleep | input | 1 | Light power-save request |
| pwr_dn | input | 1 | Full shutdown request, overrides sleep |
| code_a | input | 10 | Channel A offset-binary code |
| code_b | input | 10 | Channel B offset-binary code |
| bus_a | output | 10 | Channel A result bus, tri-stated by oe_n |
| bus_b | output | 10 | Channel B result bus, tri-stated by oe_n |
| valid_a | output | 1 | Channel A bus carries a fresh result |
| valid_b | output | 1 | Channel B bus carries a fresh result |
| mode | output | 2 | 0 active, 1 sleep, 2 shutdown, 3 waking |

## Verification
The hardest case to reach is a power request that arrives partway through waking. The counter must then be abandoned, and later restarted with the correct length. The stimulus lets the waking count run a few cycles before it raises sleep or pwr_dn, then releases the request again and measures the new waking length. A scoreboard keys each expected pair to its due cycle. Samples still in flight when the block leaves the active state are dropped from the scoreboard, so any stray output after a mode change is caught.

// File: rtl/adc_pair_outfmt_pkg.sv
package adc_pair_outfmt_pkg;
   typedef enum logic [1:0] {
      MODE_ACTIVE = 2'd0,
      MODE_SLEEP  = 2'd1,
      MODE_SHUT   = 2'd2,
      MODE_WAKE   = 2'd3
   } pmode_t;
endpackage

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
   import adc_pair_outfmt_pkg::*;
#(
   parameter int WAKE_SLEEP = 17,
   parameter int WAKE_OFF   = 60
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sleep,
   input  logic   pwr_dn,
   output pmode_t mode_o,
   output logic   active_o
);
   localparam int WMAX = (WAKE_OFF > WAKE_SLEEP) ? WAKE_OFF : WAKE_SLEEP;
   localparam int CW   = $clog2(WMAX + 1);

   pmode_t        state_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MODE_ACTIVE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            MODE_ACTIVE: begin
               if (pwr_dn)     state_q <= MODE_SHUT;
               else if (sleep) state_q <= MODE_SLEEP;
            end
            MODE_SLEEP: begin
               if (pwr_dn) state_q <= MODE_SHUT;
               else if (!sleep) begin
                  state_q <= MODE_WAKE;
                  cnt_q   <= CW'(WAKE_SLEEP - 1);
               end
            end
            MODE_SHUT: begin
               if (!pwr_dn && !sleep) begin
                  state_q <= MODE_WAKE;
                  cnt_q   <= CW'(WAKE_OFF - 1);
               end
            end
            MODE_WAKE: begin
               if (pwr_dn)             state_q <= MODE_SHUT;
               else if (sleep)         state_q <= MODE_SLEEP;
               else if (cnt_q == '0)   state_q <= MODE_ACTIVE;
               else                    cnt_q   <= cnt_q - 1'b1;
            end
         endcase
      end
   end

   assign mode_o   = state_q;
   assign active_o = (state_q == MODE_ACTIVE);

   AST_PD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> mode_o == MODE_SHUT); // R9
   AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && !pwr_dn && mode_o != MODE_SHUT) |=> mode_o == MODE_SLEEP); // R6
   AST_ACTIVE_VIA_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_ACTIVE && $past(mode_o) != MODE_ACTIVE) |-> $past(mode_o) == MODE_WAKE); // R8
endmodule

// File: rtl/adc_chan_pipe.sv
module adc_chan_pipe #(
   parameter int W   = 10,
   parameter int LAT = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active_i,
   input  logic         fmt_twos,
   input  logic [W-1:0] code_i,
   output logic [W-1:0] data_o,
   output logic         valid_o
);
   localparam int FW = $clog2(LAT + 1);

   logic [W-1:0]  stage_q [LAT];
   logic [FW-1:0] fill_q;
   logic          full;
   logic [W-1:0]  conv;

   for (genvar i = 0; i < LAT; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        stage_q[0] <= '0;
            else if (active_i) stage_q[0] <= code_i;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        stage_q[i] <= '0;
            else if (active_i) stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign full = (fill_q == FW'(LAT));
   assign conv = fmt_twos ? {~stage_q[LAT-1][W-1], stage_q[LAT-1][W-2:0]}
                          : stage_q[LAT-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q  <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         if (!active_i)  fill_q <= '0;
         else if (!full) fill_q <= fill_q + 1'b1;
         if (active_i && full) data_o <= conv;
         valid_o <= active_i && full;
      end
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> $stable(data_o)); // R6
   AST_VALID_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(active_i)); // R7
endmodule

// File: rtl/adc_pair_outfmt.sv
module adc_pair_outfmt
   import adc_pair_outfmt_pkg::*;
#(
   parameter int W          = 10,
   parameter int LAT        = 5,
   parameter int WAKE_SLEEP = 17,
   parameter int WAKE_OFF   = 60
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fmt_twos,
   input  logic         oe_n,
   input  logic         sleep,
   input  logic         pwr_dn,
   input  logic [W-1:0] code_a,
   input  logic [W-1:0] code_b,
   output logic [W-1:0] bus_a,
   output logic [W-1:0] bus_b,
   output logic         valid_a,
   output logic         valid_b,
   output logic [1:0]   mode
);
   localparam int NCH = 2;

   if (W < 2)          begin : g_bad_w    $error("W must be at least 2");        end
   if (LAT < 1)        begin : g_bad_lat  $error("LAT must be at least 1");      end
   if (WAKE_SLEEP < 1) begin : g_bad_ws   $error("WAKE_SLEEP must be positive"); end
   if (WAKE_OFF < 1)   begin : g_bad_wo   $error("WAKE_OFF must be positive");   end

   pmode_t       mode_s;
   logic         active_s;
   logic [W-1:0] code_v [NCH];
   logic [W-1:0] data_v [NCH];
   logic         vld_v  [NCH];

   adc_pwr_seq #(.WAKE_SLEEP(WAKE_SLEEP), .WAKE_OFF(WAKE_OFF)) seq_i (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .pwr_dn(pwr_dn),
      .mode_o(mode_s), .active_o(active_s)
   );

   assign code_v[0] = code_a;
   assign code_v[1] = code_b;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      adc_chan_pipe #(.W(W), .LAT(LAT)) pipe_i (
         .clk(clk), .rst_n(rst_n), .active_i(active_s), .fmt_twos(fmt_twos),
         .code_i(code_v[c]), .data_o(data_v[c]), .valid_o(vld_v[c])
      );
   end

   assign bus_a   = oe_n ? {W{1'bz}} : data_v[0];
   assign bus_b   = oe_n ? {W{1'bz}} : data_v[1];
   assign valid_a = vld_v[0];
   assign valid_b = vld_v[1];
   assign mode    = mode_s;

   AST_CH_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      valid_a == valid_b); // R2
   AST_VALID_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_a |-> $past(mode_s) == MODE_ACTIVE); // R7
endmodule

// File: tb/adc_pair_outfmt_tb_top.sv
module adc_pair_outfmt_tb_top;
   localparam int WS = 17;
   localparam int WO = 60;

   logic clk = 1'b0, rst_n = 1'b0;
   logic fmt_twos = 1'b0, oe_n = 1'b0, sleep = 1'b0, pwr_dn = 1'b0;
   logic [9:0] code_a = '0, code_b = '0;
   logic [9:0] bus_a, bus_b;
   logic valid_a, valid_b;
   logic [1:0] mode;

   adc_pair_outfmt dut_i (
      .clk(clk), .rst_n(rst_n), .fmt_twos(fmt_twos), .oe_n(oe_n),
      .sleep(sleep), .pwr_dn(pwr_dn), .code_a(code_a), .code_b(code_b),
      .bus_a(bus_a), .bus_b(bus_b), .valid_a(valid_a), .valid_b(valid_b),
      .mode(mode)
   );

   always #5 clk = ~clk;

   typedef struct { logic [9:0] a; logic [9:0] b; int due; } exp_t;
   exp_t sb_q[$];
   int n_chk = 0, n_fail = 0, n_pop = 0, cyc = 0, seq = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [9:0] fmt_of(input logic [9:0] x, input logic t);
      return t ? {~x[9], x[8:0]} : x;
   endfunction

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic report();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // driver: new codes 2 ns after each edge, expected pair pushed when active
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         logic [9:0] a, b;
         exp_t e;
         if (mode != 2'd0) sb_q = sb_q.find(x) with (x.due <= cyc);
         case (seq)
            0: a = 10'h200;
            1: a = 10'h3FF;
            2: a = 10'h000;
            default: a = 10'((seq * 37 + 11) % 1024);
         endcase
         b = a ^ 10'h155;
         seq++;
         code_a = a;
         code_b = b;
         if (mode == 2'd0) begin
            e.a = fmt_of(a, fmt_twos);
            e.b = fmt_of(b, fmt_twos);
            e.due = cyc + 6;
            sb_q.push_back(e);
         end
      end
   end

   // monitor: compares every valid output against the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(valid_a === valid_b, "R2", "channel valid alignment", 32'(valid_a), 32'(valid_b));
         if (valid_a === 1'b1) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R2", "output with nothing expected", 32'(bus_a), 32'hffff);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               n_pop++;
               chk(cyc == e.due, "R2", "latency due cycle", 32'(cyc), 32'(e.due));
               if (oe_n === 1'b0) begin
                  chk(bus_a === e.a, "R3", "bus_a coding", 32'(bus_a), 32'(e.a));
                  chk(bus_b === e.b, "R3", "bus_b coding", 32'(bus_b), 32'(e.b));
               end else begin
                  chk(bus_a === 10'bz, "R4", "bus_a float", 32'(bus_a), 32'h3ff);
               end
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "R1", "watchdog expired", 32'(cyc), 32'd20000);
         report();
      end
   end

   task automatic count_wake(input int expn, input string req);
      int n = 0;
      while (mode == 2'd3 && n < 500) begin
         n++;
         @(negedge clk);
      end
      chk(n == expn, req, "waking length", 32'(n), 32'(expn));
      chk(mode == 2'd0, req, "mode after waking", 32'(mode), 32'd0);
   endtask

   initial begin
      logic [9:0] held_a, held_b;
      repeat (3) begin
         @(negedge clk);
         chk(mode == 2'd0, "R1", "reset mode", 32'(mode), 32'd0);
         chk(valid_a == 1'b0 && valid_b == 1'b0, "R1", "reset valid", 32'(valid_a), 32'd0);
         chk(bus_a == 10'd0, "R1", "reset bus_a", 32'(bus_a), 32'd0);
      end
      @(posedge clk); #1 rst_n = 1'b1;

      // offset binary stream, latency and coding
      repeat (30) @(posedge clk);
      chk(n_pop >= 20, "R2", "outputs seen in first stream", 32'(n_pop), 32'd20);

      // output enable high while data flows (R4)
      @(posedge clk); #3 oe_n = 1'b1;
      step();
      chk(bus_a === 10'bz && bus_b === 10'bz, "R4", "buses float", 32'(bus_a), 32'h3ff);
      repeat (5) @(posedge clk);
      #3 oe_n = 1'b0;
      repeat (10) @(posedge clk);

      // sleep entry and hold (R6)
      #3 sleep = 1'b1;
      step();
      chk(mode == 2'd1, "R6", "sleep mode", 32'(mode), 32'd1);
      held_a = bus_a; held_b = bus_b;
      fmt_twos = 1'b1;
      repeat (8) begin
         step();
         chk(valid_a == 1'b0, "R6", "valid low in sleep", 32'(valid_a), 32'd0);
         chk(bus_a == held_a && bus_b == held_b, "R6", "bus held in sleep", 32'(bus_a), 32'(held_a));
      end
      @(posedge clk); #3 sleep = 1'b0;
      step();
      count_wake(WS, "R7");
      repeat (30) @(posedge clk);

      // shutdown entry, hold and float (R5), exit delay (R8)
      #3 pwr_dn = 1'b1;
      step();
      chk(mode == 2'd2, "R5", "shutdown mode", 32'(mode), 32'd2);
      held_a = bus_a; held_b = bus_b;
      repeat (5) begin
         step();
         chk(valid_a == 1'b0, "R5", "valid low in shutdown", 32'(valid_a), 32'd0);
         chk(bus_a == held_a && bus_b == held_b, "R5", "bus held in shutdown", 32'(bus_b), 32'(held_b));
      end
      @(posedge clk); #3 oe_n = 1'b1;
      @(negedge clk);
      chk(bus_a === 10'bz && bus_b === 10'bz, "R5", "float in shutdown", 32'(bus_b), 32'h3ff);
      @(posedge clk); #3 oe_n = 1'b0;
      @(negedge clk);
      chk(bus_a == held_a, "R5", "value kept after float", 32'(bus_a), 32'(held_a));
      fmt_twos = 1'b0;
      @(posedge clk); #3 pwr_dn = 1'b0;
      step();
      count_wake(WO, "R8");
      repeat (20) @(posedge clk);

      // both requests: shutdown wins and persists (R9)
      #3 begin sleep = 1'b1; pwr_dn = 1'b1; end
      step();
      chk(mode == 2'd2, "R9", "both requests", 32'(mode), 32'd2);
      @(posedge clk); #3 pwr_dn = 1'b0;
      step();
      chk(mode == 2'd2, "R9", "shutdown persists on sleep", 32'(mode), 32'd2);
      @(posedge clk); #3 sleep = 1'b0;
      step();
      count_wake(WO, "R9");
      repeat (15) @(posedge clk);

      // requests during waking (R10)
      #3 sleep = 1'b1;
      step();
      @(posedge clk); #3 sleep = 1'b0;
      step();
      repeat (4) step();
      chk(mode == 2'd3, "R10", "still waking", 32'(mode), 32'd3);
      @(posedge clk); #3 sleep = 1'b1;
      step();
      chk(mode == 2'd1, "R10", "sleep during waking", 32'(mode), 32'd1);
      @(posedge clk); #3 sleep = 1'b0;
      step();
      count_wake(WS, "R10");
      @(posedge clk); #3 sleep = 1'b1;
      step();
      @(posedge clk); #3 sleep = 1'b0;
      step();
      repeat (3) step();
      @(posedge clk); #3 pwr_dn = 1'b1;
      step();
      chk(mode == 2'd2, "R10", "shutdown during waking", 32'(mode), 32'd2);
      @(posedge clk); #3 pwr_dn = 1'b0;
      step();
      count_wake(WO, "R10");
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(n_pop >= 100, "R2", "total outputs", 32'(n_pop), 32'd100);
      report();
   end
endmodule